// File: doc/BRIEF.md
# Wraparound Burst Address Sequencer

This block produces the address of each beat in a short memory burst. When an access begins, it captures a full start address. The low bits of that address give the start offset within an aligned group of four. After that, the low bits step through the group one beat at a time while the upper bits stay fixed. A controller uses the result to drive a memory array, beat by beat, without computing the burst order itself.

Two access strobes are provided, both active low, and either one starts a burst. The advance input is also active low. The sequence moves one beat on each clock edge where advance is low, and it holds the current beat while advance is high. This lets a master pause a burst and resume it later.

A strap input picks the beat order. Linear order counts upward modulo four. Interleaved order XORs the start offset with the beat count. The strap is expected to stay static while bursts are in progress. The outputs are registered state decoded combinationally. The address for a load therefore appears in the cycle after the load edge, and each advance becomes visible in the cycle after its edge.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low, and after it is released with no further input, burst_addr is 0 and beat_idx is 0.
- R2: If strb_cpu_n or strb_ctl_n is low at a rising edge, then after that edge burst_addr equals the addr_in sampled at the edge and beat_idx is 0.
- R3: If both strobes are low at the same edge, the load is identical to a load by one strobe.
- R4: A load takes priority over advance. When a strobe is low, adv_n has no effect at that edge and beat_idx still becomes 0.
- R5: If no strobe is low and adv_n is low at an edge, beat_idx increments by one, modulo 4.
- R6: If no strobe is low and adv_n is high at an edge, beat_idx and burst_addr do not change (burst suspend).
- R7: With order_sel = 0 (linear), burst_addr[1:0] equals (start offset + beat_idx) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R8: With order_sel = 1 (interleaved), burst_addr[1:0] equals start offset XOR beat_idx. For example, start 10 gives 10, 11, 00, 01, and start 11 gives 11, 10, 01, 00.
- R9: Advancing past the fourth beat wraps back to the first address of the same group. The sequence keeps cycling within that group.
- R10: burst_addr[ADDR_W-1:2] changes only at an edge where a strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| order_sel | input | 1 | Burst order strap: 0 selects linear, 1 selects interleaved |
| strb_cpu_n | input | 1 | First access strobe, active low |
| strb_ctl_n | input | 1 | Second access strobe, active low |
| adv_n | input | 1 | Advance to next beat, active low |
| addr_in | input | ADDR_W | Start address, captured on a strobe |
| burst_addr | output | ADDR_W | Address of the current beat |
| beat_idx | output | OFFS_W | Beats advanced since the last load, modulo 4 |

## Verification
The bench builds the block with its defaults: a 16-bit address and a 2-bit offset. With these values every start offset can be reached in both orders, and a wrap happens after only four advances. Directed bursts cover each start offset in each order for six advances, which also crosses the wrap. Random traffic then mixes strobes, advances and holds over the 14 upper bits, so that loads collide with advances and suspends land in the middle of bursts.

// File: rtl/burst_seq_pkg.sv
`timescale 1ns/1ps
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_load_ctrl.sv
`timescale 1ns/1ps
module burst_load_ctrl (
  input  logic strb_a_n,
  input  logic strb_b_n,
  input  logic adv_n,
  output logic load,
  output logic step
);
  // Either strobe starts a burst; advance only counts when no load is present.
  always_comb begin
    load = ~(strb_a_n & strb_b_n);
    step = ~load & ~adv_n;
  end
endmodule

// File: rtl/burst_beat_cnt.sv
`timescale 1ns/1ps
module burst_beat_cnt #(
  parameter int OFFS_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  output logic [OFFS_W-1:0] beat
);
  localparam logic [OFFS_W-1:0] ONE = OFFS_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)    beat <= '0;
    else if (load) beat <= '0;
    else if (step) beat <= beat + ONE;  // natural wrap modulo 2**OFFS_W
  end
endmodule

// File: rtl/burst_addr_hold.sv
`timescale 1ns/1ps
module burst_addr_hold #(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [ADDR_W-1:0]        addr_in,
  output logic [OFFS_W-1:0]        start_off,
  output logic [ADDR_W-OFFS_W-1:0] upper
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_off <= '0;
      upper     <= '0;
    end else if (load) begin
      start_off <= addr_in[OFFS_W-1:0];
      upper     <= addr_in[ADDR_W-1:OFFS_W];
    end
  end
endmodule

// File: rtl/burst_order_map.sv
`timescale 1ns/1ps
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int OFFS_W = 2
) (
  input  logic [OFFS_W-1:0] start_off,
  input  logic [OFFS_W-1:0] beat,
  input  order_e            order,
  output logic [OFFS_W-1:0] offset
);
  logic [OFFS_W-1:0] off_lin;
  logic [OFFS_W-1:0] off_xor;

  assign off_lin = start_off + beat;

  // Interleaved order: each offset bit toggles with the matching beat bit.
  for (genvar gi = 0; gi < OFFS_W; gi++) begin : g_xor
    assign off_xor[gi] = start_off[gi] ^ beat[gi];
  end

  always_comb begin
    unique case (order)
      ORD_INTERLEAVE: offset = off_xor;
      default:        offset = off_lin;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
`timescale 1ns/1ps
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              order_sel,
  input  logic              strb_cpu_n,
  input  logic              strb_ctl_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] burst_addr,
  output logic [OFFS_W-1:0] beat_idx
);
  localparam int UP_W = ADDR_W - OFFS_W;

  logic              load;
  logic              step;
  logic [OFFS_W-1:0] start_off;
  logic [UP_W-1:0]   upper;
  logic [OFFS_W-1:0] offset;
  order_e            order;

  assign order = order_e'(order_sel);

  burst_load_ctrl u_ctrl (
    .strb_a_n (strb_cpu_n),
    .strb_b_n (strb_ctl_n),
    .adv_n    (adv_n),
    .load     (load),
    .step     (step)
  );

  burst_beat_cnt #(.OFFS_W(OFFS_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (step),
    .beat  (beat_idx)
  );

  burst_addr_hold #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .addr_in   (addr_in),
    .start_off (start_off),
    .upper     (upper)
  );

  burst_order_map #(.OFFS_W(OFFS_W)) u_map (
    .start_off (start_off),
    .beat      (beat_idx),
    .order     (order),
    .offset    (offset)
  );

  assign burst_addr = {upper, offset};
endmodule

// File: rtl/burst_addr_seq_chk.sv
`timescale 1ns/1ps
module burst_addr_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              order_sel,
  input logic              strb_cpu_n,
  input logic              strb_ctl_n,
  input logic              adv_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] burst_addr,
  input logic [OFFS_W-1:0] beat_idx
);
  logic ld;
  logic [OFFS_W-1:0] lo;
  assign ld = !strb_cpu_n || !strb_ctl_n;
  assign lo = burst_addr[OFFS_W-1:0];

  // R2, R3: a load presents the captured address and beat zero
  assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (burst_addr == $past(addr_in)) && (beat_idx == '0));

  // R4: advance is ignored on a load edge
  assert_load_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !adv_n) |=> (beat_idx == '0));

  // R5: advance steps the beat by one
  assert_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !adv_n) |=> (beat_idx == OFFS_W'($past(beat_idx) + 1'b1)));

  // R6: suspend holds the beat and address
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && adv_n) |=> ($stable(beat_idx) && (!$stable(order_sel) || $stable(burst_addr))));

  // R7: linear order keeps (offset - beat) constant within a burst
  assert_linear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> (order_sel || $past(order_sel) ||
             (OFFS_W'(lo - beat_idx) == OFFS_W'($past(lo) - $past(beat_idx)))));

  // R8: interleaved order keeps (offset ^ beat) constant within a burst
  assert_interleave_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> (!order_sel || !$past(order_sel) ||
             ((lo ^ beat_idx) == ($past(lo) ^ $past(beat_idx)))));

  // R9, R10: upper address bits never move without a load
  assert_upper_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(burst_addr[ADDR_W-1:OFFS_W]));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .order_sel  (order_sel),
  .strb_cpu_n (strb_cpu_n),
  .strb_ctl_n (strb_ctl_n),
  .adv_n      (adv_n),
  .addr_in    (addr_in),
  .burst_addr (burst_addr),
  .beat_idx   (beat_idx)
);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;
  localparam int ADDR_W = 16;
  localparam int OFFS_W = 2;
  localparam int UP_W   = ADDR_W - OFFS_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              order_sel = 1'b0;
  logic              strb_cpu_n = 1'b1;
  logic              strb_ctl_n = 1'b1;
  logic              adv_n = 1'b1;
  logic [ADDR_W-1:0] addr_in = '0;
  logic [ADDR_W-1:0] burst_addr;
  logic [OFFS_W-1:0] beat_idx;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [UP_W-1:0]   m_upper = '0;
  logic [OFFS_W-1:0] m_start = '0;
  logic [OFFS_W-1:0] m_beat  = '0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) i_burst_addr_seq (
    .clk (clk), .rst_n (rst_n), .order_sel (order_sel),
    .strb_cpu_n (strb_cpu_n), .strb_ctl_n (strb_ctl_n), .adv_n (adv_n),
    .addr_in (addr_in), .burst_addr (burst_addr), .beat_idx (beat_idx)
  );

  function automatic logic [OFFS_W-1:0] exp_off(input logic [OFFS_W-1:0] s,
                                                input logic [OFFS_W-1:0] b,
                                                input logic mode);
    if (mode) return s ^ b;          // R8 interleaved
    return OFFS_W'(s + b);           // R7 linear
  endfunction

  task automatic check(input string req);
    logic [ADDR_W-1:0] ea;
    ea = {m_upper, exp_off(m_start, m_beat, order_sel)};
    checks++;
    if (burst_addr !== ea || beat_idx !== m_beat) begin
      failures++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               req, burst_addr, beat_idx, ea, m_beat);
    end
  endtask

  task automatic step(input logic cpu_n, input logic ctl_n, input logic av_n,
                      input logic [ADDR_W-1:0] a, input string req);
    @(negedge clk);
    strb_cpu_n = cpu_n; strb_ctl_n = ctl_n; adv_n = av_n; addr_in = a;
    @(posedge clk);
    #1;
    if (!cpu_n || !ctl_n) begin
      m_upper = a[ADDR_W-1:OFFS_W];
      m_start = a[OFFS_W-1:0];
      m_beat  = '0;
    end else if (!av_n) begin
      m_beat = OFFS_W'(m_beat + 1'b1);
    end
    check(req);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after release");

    // Directed: every start offset in both orders, six advances (crosses the wrap)
    for (int md = 0; md < 2; md++) begin
      @(negedge clk); order_sel = md[0];
      for (int s = 0; s < 4; s++) begin
        step(1'b0, 1'b1, 1'b1, {14'h2a5 + 14'(s), 2'(s)}, "R2 load");
        for (int k = 0; k < 6; k++)
          step(1'b1, 1'b1, 1'b0, 16'hffff, md ? "R8 R9 interleave" : "R7 R9 linear");
        step(1'b1, 1'b1, 1'b1, 16'h0000, "R6 hold");
        step(1'b1, 1'b1, 1'b1, 16'h1234, "R6 R10 hold");
      end
    end

    // Corner cases
    step(1'b1, 1'b0, 1'b1, 16'hbeef, "R2 second strobe");
    step(1'b1, 1'b1, 1'b0, 16'h0000, "R5 advance");
    step(1'b0, 1'b0, 1'b1, 16'h5a5a, "R3 both strobes");
    step(1'b1, 1'b1, 1'b0, 16'h0000, "R5 advance");
    step(1'b1, 1'b1, 1'b0, 16'h0000, "R5 advance");
    step(1'b0, 1'b1, 1'b0, 16'hc3c1, "R4 load over advance");
    step(1'b1, 1'b0, 1'b0, 16'h7777, "R4 load over advance");

    // Random traffic
    for (int n = 0; n < 2000; n++) begin
      logic c, d, v;
      if (n % 100 == 0) begin
        @(negedge clk); order_sel = 1'($urandom);
        step(1'b0, 1'b1, 1'b1, 16'($urandom), "R2 reload after mode change");
      end
      c = ($urandom % 8) == 0 ? 1'b0 : 1'b1;
      d = ($urandom % 8) == 0 ? 1'b0 : 1'b1;
      v = 1'($urandom);
      step(c, d, v, 16'($urandom), "R5 R6 R10 random");
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule